// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time-of-Day Counter

This block keeps the time of day for a precision time protocol clock as a 64-bit count of nanoseconds. Every cycle of the datapath clock it adds an increment to an internal accumulator. The increment is a fixed-point value with 32 fraction bits, and the accumulator carries 32 bits of fractional nanoseconds below the visible count. The increment can therefore describe periods such as 1.6 ns exactly enough for long-term tracking. The integer nanoseconds are driven on `tod_ns` for timestamping logic elsewhere in the chip.

Software reaches the block over a simple 32-bit register bus. Time and increment are each split into a low and a high word. A write of the low word is only staged, and the write of the high word commits both halves at once. For reads, fetching the low time word also captures the upper half, so a later read of the high word belongs to the same instant.

A link-speed input picks a default increment that matches the datapath clock rate at that speed. Software can trim the frequency by a signed parts-per-billion amount relative to that default.

Top module: `ns_tod_counter`

## Requirements
- R1: After reset, `tod_ns` is 0, the run bit is 0, nothing is staged, and the active increment is 0x0199999999 (the default for the fastest link).
- R2: While the run bit (bit 0 of the control register, word address 0) is 1, the {time, fraction} accumulator grows by the active increment every cycle. `tod_ns` shows the integer part, and the fraction carries into it.
- R3: While the run bit is 0 and no time commit occurs, `tod_ns` holds its value.
- R4: A write to the time low word (address 1) only stages the value and does not change `tod_ns`. A write to the time high word (address 2) loads time = {high, staged low}, clears the fraction, and takes priority over that cycle's addition. The new value is visible on the next cycle.
- R5: A read of address 1 returns the current low 32 bits of time in the same cycle and captures the upper 32 bits. A read of address 2 returns the captured upper half, unaffected by later ticks.
- R6: A write to the increment low word (address 3) only stages the value and leaves the active increment unchanged. A write to the increment high word (address 4) makes the increment {high, staged low}. Reads of addresses 3 and 4 return the active increment words.
- R7: The `link_speed` encoding selects the default increment: 0 = fastest link or no link, 0x0199999999. 1 = 10G, 0x0333333333. 2 = 1G, 0x2000000000.
- R8: `link_speed` 3 (100M) selects an increment of zero, so time stops even while running.
- R9: A change on `link_speed` reloads both the base and the active increment in the second cycle after the change is applied. The active increment is left unchanged if an increment low word is staged at that point. The base is still updated in that case.
- R10: A write to address 5 sets increment = base ± floor(base × m / 1e9). Here m is wdata[30:0], wdata[31] = 1 selects subtraction, and base is the last speed-selected default. Address 5 and the unused addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_speed | input | 2 | Current link speed code (R7 encoding) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, valid in the cycle of `rd_en` |
| tod_ns | output | 64 | Integer nanoseconds of the time of day |

## Verification
The hardest situation to reach is a link-speed reload that lands while an increment low word is staged. In that case the active increment must stay put while the base behind the trim moves. The stimulus writes the increment low word first, then changes `link_speed` and lets several cycles pass before it reads the increment. Only after that does it commit the high word and issue a trim, so the trim result shows which base was latched. Snapshot coherence is reached by reading the low time word while counting and then delaying the high read across many ticks. The delay chosen makes the live upper half differ from the captured one.

// File: rtl/tod_pkg.sv
// Package: shared types, register word addresses and speed defaults for the
// nanosecond time-of-day counter. Assumes a 32-bit register bus.
package tod_pkg;
    localparam int REG_W  = 32;
    localparam int INC_W  = 2 * REG_W;   // 32.32 fixed-point increment
    localparam int TOD_W  = 2 * REG_W;   // integer nanoseconds
    localparam int FRAC_W = REG_W;       // fractional nanoseconds
    localparam int ADR_W  = 3;

    localparam logic [ADR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADR_W-1:0] A_TIME_L = 3'd1;
    localparam logic [ADR_W-1:0] A_TIME_H = 3'd2;
    localparam logic [ADR_W-1:0] A_INC_L  = 3'd3;
    localparam logic [ADR_W-1:0] A_INC_H  = 3'd4;
    localparam logic [ADR_W-1:0] A_TRIM   = 3'd5;

    typedef enum logic [1:0] {
        SPD_FAST = 2'd0,
        SPD_10G  = 2'd1,
        SPD_1G   = 2'd2,
        SPD_100M = 2'd3
    } link_spd_e;

    // Default increment per link speed, 32 fraction bits
    function automatic logic [INC_W-1:0] dflt_inc(input link_spd_e s);
        case (s)
            SPD_10G:  return 64'h0000_0003_3333_3333;
            SPD_1G:   return 64'h0000_0020_0000_0000;
            SPD_100M: return '0;
            default:  return 64'h0000_0001_9999_9999;
        endcase
    endfunction
endpackage

// File: rtl/tod_inc_ctrl.sv
// Increment control: tracks the link speed, reloads the speed default one
// cycle after a change is seen, stages the increment low word until the
// high word commits, and applies ppb trims relative to the latched base.
// Assumes at most one register write per cycle.
module tod_inc_ctrl
    import tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  link_spd_e        link_speed,
    input  logic             lo_wr,
    input  logic             hi_wr,
    input  logic             trim_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [INC_W-1:0] inc_q
);
    localparam int MAG_W  = REG_W - 1;
    localparam int PROD_W = INC_W + MAG_W;
    localparam logic [PROD_W-1:0] NS_PER_S = PROD_W'(1000000000);

    link_spd_e        speed_q;
    logic             reload_q;
    logic [REG_W-1:0] stage_q;
    logic             pend_q;
    logic [INC_W-1:0] base_q;
    logic [PROD_W-1:0] prod;
    logic [INC_W-1:0] diff;
    logic [INC_W-1:0] trim_val;

    // Trim arithmetic: base +/- base*ppb/1e9
    always_comb begin
        prod     = PROD_W'(base_q) * PROD_W'(wdata[MAG_W-1:0]);
        diff     = INC_W'(prod / NS_PER_S);
        trim_val = wdata[REG_W-1] ? (base_q - diff) : (base_q + diff);
    end

    // Speed tracking and change detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q  <= SPD_FAST;
            reload_q <= 1'b0;
        end else begin
            speed_q  <= link_speed;
            reload_q <= (link_speed != speed_q);
        end
    end

    // Low-word staging for increment writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            pend_q  <= 1'b0;
        end else if (lo_wr) begin
            stage_q <= wdata;
            pend_q  <= 1'b1;
        end else if (hi_wr) begin
            pend_q  <= 1'b0;
        end
    end

    // Base tracks the last speed-selected default
    always_ff @(posedge clk) begin
        if (!rst_n)        base_q <= dflt_inc(SPD_FAST);
        else if (reload_q) base_q <= dflt_inc(speed_q);
    end

    // Active increment: software commit, then trim, then speed reload
    always_ff @(posedge clk) begin
        if (!rst_n)                   inc_q <= dflt_inc(SPD_FAST);
        else if (hi_wr)               inc_q <= {wdata, stage_q};
        else if (trim_wr)             inc_q <= trim_val;
        else if (reload_q && !pend_q) inc_q <= dflt_inc(speed_q);
    end

    p_inc_lo_staged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !reload_q) |=> $stable(inc_q));
    p_slow_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q && speed_q == SPD_100M && !pend_q && !hi_wr && !trim_wr) |=> (inc_q == '0));
    p_reload_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q && pend_q && !hi_wr && !trim_wr) |=> $stable(inc_q));
endmodule

// File: rtl/tod_accum.sv
// Accumulator: 64 integer plus 32 fractional nanosecond bits. Adds the
// active increment each running cycle; a time high-word write loads
// {high, staged low}, clears the fraction and overrides that tick.
module tod_accum
    import tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [INC_W-1:0] inc,
    input  logic             lo_wr,
    input  logic             hi_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [TOD_W-1:0] tod_ns
);
    localparam int ACC_W = TOD_W + FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic [REG_W-1:0] stage_q;

    assign tod_ns = acc_q[ACC_W-1:FRAC_W];

    // Stage the time low word
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '0;
        else if (lo_wr) stage_q <= wdata;
    end

    // Commit beats the tick; otherwise add when running
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (hi_wr)  acc_q <= {wdata, stage_q, {FRAC_W{1'b0}}};
        else if (run)    acc_q <= acc_q + ACC_W'(inc);
    end

    p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !hi_wr) |=> $stable(tod_ns));
    p_time_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> (tod_ns == {$past(wdata), $past(stage_q)}));
endmodule

// File: rtl/tod_snapshot.sv
// Snapshot: holds the upper time half captured when the low word is read,
// so that the following high-word read is coherent with it.
module tod_snapshot
    import tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [REG_W-1:0] tod_hi,
    output logic [REG_W-1:0] snap_q
);
    // Capture the upper half on a low-word read
    always_ff @(posedge clk) begin
        if (!rst_n)   snap_q <= '0;
        else if (cap) snap_q <= tod_hi;
    end

    p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (snap_q == $past(tod_hi)));
endmodule

// File: rtl/ns_tod_counter.sv
// Top: decodes the register bus, holds the run bit and muxes read data.
// Reads are combinational in the strobe cycle; one access per cycle.
module ns_tod_counter
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        link_speed,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADR_W-1:0]  addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [TOD_W-1:0]  tod_ns
);
    logic             run_q;
    logic [INC_W-1:0] inc;
    logic [REG_W-1:0] snap;
    logic             w_ctrl, w_tl, w_th, w_il, w_ih, w_trim, r_tl;

    // Write and read strobe decode
    always_comb begin
        w_ctrl = wr_en && addr == A_CTRL;
        w_tl   = wr_en && addr == A_TIME_L;
        w_th   = wr_en && addr == A_TIME_H;
        w_il   = wr_en && addr == A_INC_L;
        w_ih   = wr_en && addr == A_INC_H;
        w_trim = wr_en && addr == A_TRIM;
        r_tl   = rd_en && addr == A_TIME_L;
    end

    // Run bit
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (w_ctrl) run_q <= wdata[0];
    end

    tod_inc_ctrl u_inc (
        .clk(clk), .rst_n(rst_n), .link_speed(link_spd_e'(link_speed)),
        .lo_wr(w_il), .hi_wr(w_ih), .trim_wr(w_trim), .wdata(wdata),
        .inc_q(inc)
    );

    tod_accum u_acc (
        .clk(clk), .rst_n(rst_n), .run(run_q), .inc(inc),
        .lo_wr(w_tl), .hi_wr(w_th), .wdata(wdata), .tod_ns(tod_ns)
    );

    tod_snapshot u_snap (
        .clk(clk), .rst_n(rst_n), .cap(r_tl),
        .tod_hi(tod_ns[TOD_W-1:REG_W]), .snap_q(snap)
    );

    // Read data mux
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL:   rdata = {{(REG_W-1){1'b0}}, run_q};
                A_TIME_L: rdata = tod_ns[REG_W-1:0];
                A_TIME_H: rdata = snap;
                A_INC_L:  rdata = inc[REG_W-1:0];
                A_INC_H:  rdata = inc[INC_W-1:REG_W];
                default:  rdata = '0;
            endcase
        end
    end

    p_stopped_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !w_th && !w_ctrl) |=> !run_q);
endmodule

// File: tb/ns_tod_counter_tb_top.sv
module ns_tod_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  link_speed = 2'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] tod_ns;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ns_tod_counter dut_i (.clk(clk), .rst_n(rst_n), .link_speed(link_speed),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tod_ns(tod_ns));

    // Behavioural reference model
    logic [95:0] m_acc;
    logic [31:0] m_tstage, m_istage, m_snap;
    logic [63:0] m_inc, m_base;
    logic [1:0]  m_spd;
    bit          m_run, m_ipend, m_reload;

    function automatic logic [63:0] spd_default(input logic [1:0] s);
        if (s == 2'd1) return 64'h3_3333_3333;
        if (s == 2'd2) return 64'h20_0000_0000;
        if (s == 2'd3) return 64'h0;
        return 64'h1_9999_9999;
    endfunction

    always @(posedge clk) begin
        logic [63:0] n_inc, n_base;
        logic [127:0] p;
        logic [63:0] d;
        if (!rst_n) begin
            m_acc = '0; m_tstage = '0; m_istage = '0; m_snap = '0;
            m_inc = spd_default(0); m_base = spd_default(0);
            m_spd = 0; m_run = 0; m_ipend = 0; m_reload = 0;
        end else begin
            n_inc = m_inc; n_base = m_base;
            if (m_reload) n_base = spd_default(m_spd);
            if (wr_en && addr == 4) n_inc = {wdata, m_istage};
            else if (wr_en && addr == 5) begin
                p = 128'(m_base) * 128'(wdata[30:0]);
                d = 64'(p / 128'd1000000000);
                n_inc = wdata[31] ? m_base - d : m_base + d;
            end else if (m_reload && !m_ipend) n_inc = spd_default(m_spd);
            if (rd_en && addr == 1) m_snap = m_acc[95:64];
            if (wr_en && addr == 2) m_acc = {wdata, m_tstage, 32'h0};
            else if (m_run) m_acc = m_acc + 96'(m_inc);
            if (wr_en && addr == 0) m_run = wdata[0];
            if (wr_en && addr == 1) m_tstage = wdata;
            if (wr_en && addr == 3) begin m_istage = wdata; m_ipend = 1; end
            else if (wr_en && addr == 4) m_ipend = 0;
            m_reload = (link_speed != m_spd);
            m_spd = link_speed;
            m_inc = n_inc; m_base = n_base;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison of the visible time (R2, R3, R4, R8)
    always @(negedge clk) if (rst_n && !done) check("R2 tod_ns", tod_ns, m_acc[95:32]);

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string req, output logic [31:0] v);
        logic [31:0] e;
        @(negedge clk); rd_en = 1; addr = a;
        #1;
        case (a)
            3'd0: e = {31'b0, m_run};
            3'd1: e = m_acc[63:32];
            3'd2: e = m_snap;
            3'd3: e = m_inc[31:0];
            3'd4: e = m_inc[63:32];
            default: e = '0;
        endcase
        v = rdata;
        check(req, 64'(rdata), 64'(e));
        @(negedge clk); rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, lo_seen;
        logic [63:0] frozen;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset tod", tod_ns, 64'h0);
        rd(3, "R1 inc lo", v); check("R1 inc lo value", 64'(v), 64'h9999_9999);
        rd(4, "R1 inc hi", v); check("R1 inc hi value", 64'(v), 64'h1);
        rd(0, "R1 run bit", v); check("R1 run value", 64'(v), 64'h0);

        wr(0, 1); idle(20);                                  // R2 counting
        check("R2 advanced", 64'(tod_ns != 0), 64'h1);
        wr(0, 0); frozen = tod_ns; idle(10);                 // R3 stopped
        check("R3 held", tod_ns, frozen);
        wr(0, 1);

        wr(1, 32'hFFFF_FFF0); idle(5);                       // R4 staged only
        wr(2, 32'h0000_0005); idle(1);
        check("R4 commit", 64'(tod_ns >= 64'h5_FFFF_FFF0), 64'h1);

        idle(3);                                             // R5 coherent read
        rd(1, "R5 time lo", lo_seen);
        idle(15);
        rd(2, "R5 time hi", v); check("R5 hi is snapshot", 64'(v), 64'h5);
        rd(6, "R10 unused addr", v);

        wr(3, 32'h8000_0000); idle(6);                       // R6 staged increment
        rd(4, "R6 inc unchanged", v); check("R6 inc hi old", 64'(v), 64'h1);
        wr(4, 32'h0000_0002); idle(10);
        rd(4, "R6 inc committed", v); check("R6 inc hi new", 64'(v), 64'h2);

        link_speed = 2'd1; idle(4);                          // R7 10G
        rd(4, "R7 10G hi", v); check("R7 10G hi value", 64'(v), 64'h3);
        link_speed = 2'd2; idle(4);                          // R7 1G
        rd(4, "R7 1G hi", v); check("R7 1G hi value", 64'(v), 64'h20);
        link_speed = 2'd3; idle(4);                          // R8 stop
        frozen = tod_ns; idle(10);
        check("R8 stopped", tod_ns, frozen);
        wr(5, 32'd500000); idle(3);
        rd(4, "R8 trim on zero base", v);

        link_speed = 2'd1; idle(4);                          // R9 reload skipped
        wr(3, 32'h1234_5678);
        link_speed = 2'd2; idle(5);
        rd(4, "R9 inc kept", v); check("R9 inc hi kept", 64'(v), 64'h3);
        wr(4, 32'h4); idle(3);
        wr(5, 32'd100000000); idle(2);                       // R10 +10% on 1G base
        rd(4, "R10 trim hi", v); check("R10 plus hi", 64'(v), 64'h23);
        rd(3, "R10 trim lo", v); check("R10 plus lo", 64'(v), 64'h3333_3333);
        wr(5, 32'h8000_0000 | 32'd250000000); idle(2);       // R10 -25%
        rd(4, "R10 minus hi", v); check("R10 minus hi value", 64'(v), 64'h18);
        rd(5, "R10 trim reads zero", v);
        idle(20);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule